// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches a bank of external pins and turns selected activity on them into latched, maskable interrupt requests. Each pin is first brought into the clock domain through a flop chain. A per-pin trigger code then picks what counts as an event: a held low or high level, a falling or rising transition, or any transition. A detected event sets the pin's sticky pending bit. Software clears a pending bit by writing a one to it.

A mask register decides which pending bits may reach the single combined interrupt line that feeds a downstream interrupt controller. Masking only hides a bit from that line. The pending bit itself is still recorded, so software can poll sources that it keeps masked.

All configuration and status sits behind a plain word-wide bus with separate write and read strobes. Read data is registered.

Top module: `pin_event_irq`

## Requirements
- R1: After reset every trigger field reads 15 (detection off), every mask bit reads 1, the pending register reads 0, `irq_o` is 0 and `bus_rdata` is 0.
- R2: Pin p's 4-bit trigger code sits in word p/8 at bits 4*(p%8) to 4*(p%8)+3. Config words are at addresses 0 to C-1, where C = ceil(NUM_PINS/8). Written codes read back unchanged.
- R3: Code 0 raises an event on every cycle the synchronised pin is 0. Code 1 raises an event on every cycle it is 1.
- R4: Code 2 raises an event when the synchronised pin goes from 1 to 0 against its value one cycle earlier. Code 3 raises an event on the change from 0 to 1.
- R5: Code 4 raises an event on either transition. Codes 5 to 15 never raise one.
- R6: The pending register is at address C, one bit per pin with pin p at bit p. A write there clears each bit written as 1 and leaves each bit written as 0 unchanged. A pending bit never falls without such a write.
- R7: If an event and a write-1 clear reach the same bit on the same clock edge, the bit stays set. A level-mode pin that is still active therefore cannot be cleared.
- R8: The mask register is at address C+1, one bit per pin. A mask bit of 1 blocks its pin from `irq_o` but does not stop the pending bit from setting. `irq_o` is registered and equals the OR of pending AND NOT mask as it stood one cycle earlier.
- R9: A pin change sampled on clock edge k sets the pending bit on edge k+2 and drives `irq_o` on edge k+3.
- R10: A read strobe sampled on edge k loads `bus_rdata` on that edge. Reading any address above C+1 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous external pins |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The main sweep runs 16 rounds. Each round gives every pin a different trigger code, with codes staggered by pin index, and drives a fixed per-pin before/after pin pair: low to low, high to low, low to high, or high to high. Over the rounds every code meets every pair. This separates level detection from edge detection and rising from falling, and it shows that codes 5 to 15 stay silent. It also shows whether each field lands on the right pin.

Each round then unmasks all pins and afterwards masks exactly the pending ones. This tells a mask gating `irq_o` apart from one that suppresses pending. Directed sequences time the pin-to-interrupt latency edge by edge. They also place a clear on the same edge as an edge event, and try to clear a still-active level source.

// File: rtl/gei_pkg.sv
package gei_pkg;
  localparam int MODE_W          = 4;
  localparam int BUS_W           = 32;
  localparam int FIELDS_PER_WORD = BUS_W / MODE_W;

  typedef logic [MODE_W-1:0] trig_t;

  localparam trig_t TRIG_LOW  = 4'd0;
  localparam trig_t TRIG_HIGH = 4'd1;
  localparam trig_t TRIG_FALL = 4'd2;
  localparam trig_t TRIG_RISE = 4'd3;
  localparam trig_t TRIG_BOTH = 4'd4;
  localparam trig_t TRIG_OFF  = 4'd15;

  function automatic int cfg_words(input int pins);
    return (pins + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
  endfunction
endpackage

// File: rtl/gei_sync.sv
module gei_sync #(
  parameter int NUM_PINS = 32,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] prv_o
);
  logic [NUM_PINS-1:0] stg_q [STAGES];
  logic [NUM_PINS-1:0] prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prv_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prv_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o = stg_q[STAGES-1];
  assign prv_o = prv_q;
endmodule

// File: rtl/gei_detect.sv
module gei_detect
  import gei_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        lvl_i,
  input  logic [NUM_PINS-1:0]        prv_i,
  input  logic [NUM_PINS*MODE_W-1:0] cfg_i,
  output logic [NUM_PINS-1:0]        evt_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    trig_t mode_w;
    assign mode_w = cfg_i[p*MODE_W +: MODE_W];

    always_comb begin
      case (mode_w)
        TRIG_LOW:  evt_o[p] = ~lvl_i[p];
        TRIG_HIGH: evt_o[p] = lvl_i[p];
        TRIG_FALL: evt_o[p] = prv_i[p] & ~lvl_i[p];
        TRIG_RISE: evt_o[p] = ~prv_i[p] & lvl_i[p];
        TRIG_BOTH: evt_o[p] = prv_i[p] ^ lvl_i[p];
        default:   evt_o[p] = 1'b0;
      endcase
    end

    // R4 / R5: an edge-mode event requires the synchronised pin to have moved
    a_r4_edge_needs_change: assert property (@(posedge clk) disable iff (rst)
      (evt_o[p] && (mode_w == TRIG_FALL || mode_w == TRIG_RISE || mode_w == TRIG_BOTH))
      |-> (lvl_i[p] != prv_i[p]));
  end
endmodule

// File: rtl/gei_regs.sv
module gei_regs
  import gei_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_i,
  input  logic                       rd_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [BUS_W-1:0]           wdata_i,
  input  logic [NUM_PINS-1:0]        evt_i,
  output logic [NUM_PINS*MODE_W-1:0] cfg_o,
  output logic [NUM_PINS-1:0]        mask_o,
  output logic [NUM_PINS-1:0]        pend_o,
  output logic [BUS_W-1:0]           rdata_o
);
  localparam int CFG_WORDS = cfg_words(NUM_PINS);
  localparam int PEND_ADDR = CFG_WORDS;
  localparam int MASK_ADDR = CFG_WORDS + 1;

  logic [NUM_PINS*MODE_W-1:0] cfg_q;
  logic [NUM_PINS-1:0]        mask_q, pend_q, clr_w;
  logic [BUS_W-1:0]           rd_word, rdata_q;
  logic                       pend_wr;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
    localparam int WORD = p / FIELDS_PER_WORD;
    localparam int OFS  = (p % FIELDS_PER_WORD) * MODE_W;
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[p*MODE_W +: MODE_W] <= TRIG_OFF;
      else if (wr_i && addr_i == ADDR_W'(WORD))
        cfg_q[p*MODE_W +: MODE_W] <= wdata_i[OFS +: MODE_W];
    end
  end

  assign pend_wr = wr_i && (addr_i == ADDR_W'(PEND_ADDR));
  assign clr_w   = pend_wr ? wdata_i[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (wr_i && addr_i == ADDR_W'(MASK_ADDR)) mask_q <= wdata_i[NUM_PINS-1:0];
      pend_q <= (pend_q & ~clr_w) | evt_i;
    end
  end

  always_comb begin
    rd_word = '0;
    if (int'(addr_i) < CFG_WORDS) begin
      for (int p = 0; p < NUM_PINS; p++)
        if (int'(addr_i) == p / FIELDS_PER_WORD)
          rd_word[(p % FIELDS_PER_WORD)*MODE_W +: MODE_W] = cfg_q[p*MODE_W +: MODE_W];
    end else if (int'(addr_i) == PEND_ADDR) begin
      rd_word = BUS_W'(pend_q);
    end else if (int'(addr_i) == MASK_ADDR) begin
      rd_word = BUS_W'(mask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_i ? rd_word : '0;
  end

  assign cfg_o   = cfg_q;
  assign mask_o  = mask_q;
  assign pend_o  = pend_q;
  assign rdata_o = rdata_q;

  // R6: a bit written with 1 and not hit by an event is gone on the next cycle
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (rst)
    pend_wr |=> ((pend_q & $past(clr_w & ~evt_i)) == '0));
  // R6: without a pending write no bit may fall
  a_r6_no_silent_drop: assert property (@(posedge clk) disable iff (rst)
    !pend_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R7 / R8: every event lands in pending, whatever the clear or the mask says
  a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import gei_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(((NUM_PINS + 7) / 8) + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  output logic                irq_o
);
  logic [NUM_PINS-1:0]        lvl_w, prv_w, evt_w, mask_w, pend_w;
  logic [NUM_PINS*MODE_W-1:0] cfg_w;
  logic                       irq_q;

  gei_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .lvl_o(lvl_w), .prv_o(prv_w)
  );

  gei_detect #(.NUM_PINS(NUM_PINS)) i_detect (
    .clk(clk), .rst(rst), .lvl_i(lvl_w), .prv_i(prv_w), .cfg_i(cfg_w), .evt_o(evt_w)
  );

  gei_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .rd_i(bus_rd), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .evt_i(evt_w), .cfg_o(cfg_w), .mask_o(mask_w),
    .pend_o(pend_w), .rdata_o(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend_w & ~mask_w);
  end

  assign irq_o = irq_q;

  // R8: with every pin masked the line must be low one cycle later
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (&mask_w) |=> !irq_o);
  // R8: an unmasked pending bit must raise the line one cycle later
  a_r8_unmasked_raises: assert property (@(posedge clk) disable iff (rst)
    (|(pend_w & ~mask_w)) |=> irq_o);
endmodule

// File: tb/test_pin_event_irq.sv
`timescale 1ns/1ps
module test_pin_event_irq;
  localparam int NP = 8;
  localparam int AW = 2;
  localparam logic [AW-1:0] A_CFG = 2'd0, A_PEND = 2'd1, A_MASK = 2'd2, A_NONE = 2'd3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_event_irq #(.NUM_PINS(NP), .SYNC_STAGES(2), .ADDR_W(AW)) i_pin_event_irq (
    .clk(clk), .rst(rst), .pin_i(pins), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit detect_ref(input int code, input bit a, input bit b);
    case (code)
      0: return !a || !b;
      1: return a || b;
      2: return a && !b;
      3: return !a && b;
      4: return a != b;
      default: return 1'b0;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r, cfgw;
    logic [NP-1:0] exp_p, a_vec, b_vec;
    idle(3);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
    chk(rdata == 32'd0, "R1 rdata", rdata, 32'd0);
    bus_read(A_CFG, r);  chk(r == 32'hFFFF_FFFF, "R1 cfg", r, 32'hFFFF_FFFF);
    bus_read(A_PEND, r); chk(r == 32'd0, "R1 pend", r, 32'd0);
    bus_read(A_MASK, r); chk(r == 32'h0000_00FF, "R1 mask", r, 32'hFF);

    // R3 R4 R5 R2 R8: staggered-code sweep
    for (int i = 0; i < NP; i++) begin
      a_vec[i] = i[0];
      b_vec[i] = i[1];
    end
    for (int c = 0; c < 16; c++) begin
      cfgw = '0; exp_p = '0;
      for (int i = 0; i < NP; i++) begin
        cfgw[4*i +: 4] = 4'((c + i) % 16);
        exp_p[i] = detect_ref((c + i) % 16, a_vec[i], b_vec[i]);
      end
      bus_write(A_CFG, 32'hFFFF_FFFF);
      pins = a_vec;
      idle(4);
      bus_write(A_PEND, 32'hFF);
      bus_write(A_CFG, cfgw);
      idle(4);
      pins = b_vec;
      idle(5);
      bus_read(A_CFG, r);  chk(r == cfgw, "R2 field layout", r, cfgw);
      bus_read(A_PEND, r); chk(r == {24'd0, exp_p}, "R3 R4 R5 detection", r, {24'd0, exp_p});
      bus_write(A_MASK, 32'h0);
      idle(1);
      chk(irq == (exp_p != 0), "R8 unmasked irq", {31'd0, irq}, {31'd0, exp_p != 0});
      bus_write(A_MASK, {24'd0, exp_p});
      idle(1);
      chk(irq == 1'b0, "R8 masked irq", {31'd0, irq}, 32'd0);
      bus_write(A_MASK, 32'hFF);
    end

    // R9 latency: pin 0 rising, only pin 0 unmasked
    bus_write(A_CFG, 32'hFFFF_FFF3);
    pins = '0;
    idle(4);
    bus_write(A_PEND, 32'hFF);
    bus_write(A_MASK, 32'hFE);
    @(negedge clk); pins = 8'h01;
    idle(3);
    chk(irq == 1'b0, "R9 irq not before k+3", {31'd0, irq}, 32'd0);
    idle(1);
    chk(irq == 1'b1, "R9 irq at k+3", {31'd0, irq}, 32'd1);

    // R7 clear and edge event on the same edge
    bus_write(A_MASK, 32'hFF);
    pins = '0;
    idle(4);
    bus_write(A_PEND, 32'hFF);
    @(negedge clk); pins = 8'h01;
    @(negedge clk);
    bus_write(A_PEND, 32'h01);
    bus_read(A_PEND, r); chk(r == 32'h1, "R7 event beats clear", r, 32'h1);
    // R6 write of 0 leaves the bit, write of 1 clears it
    bus_write(A_PEND, 32'h00);
    bus_read(A_PEND, r); chk(r == 32'h1, "R6 zero write no effect", r, 32'h1);
    bus_write(A_PEND, 32'h01);
    bus_read(A_PEND, r); chk(r == 32'h0, "R6 one write clears", r, 32'h0);

    // R7 active high level cannot be cleared; R3 clears once inactive
    bus_write(A_CFG, 32'hFFFF_FFF1);
    idle(3);
    bus_write(A_PEND, 32'hFF);
    bus_read(A_PEND, r); chk(r == 32'h1, "R7 level keeps pending", r, 32'h1);
    pins = '0;
    idle(4);
    bus_write(A_PEND, 32'hFF);
    bus_read(A_PEND, r); chk(r == 32'h0, "R3 level released", r, 32'h0);

    // R10 unmapped address
    bus_read(A_NONE, r); chk(r == 32'h0, "R10 unmapped read", r, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule